// File: doc/BRIEF.md
# TDM Transmit Slot Gating Controller

This block decides, slot by slot, whether a time-division-multiplexed serial audio transmitter drives a data word or leaves its data pins in high impedance. A 32-bit enable mask holds one bit per slot. Software reaches the mask as two 16-bit halves in 24-bit bus words over a simple register port. A write-only blanking register lets software cancel the slot in progress, or the slot that starts in the same cycle, without touching the mask. An external frame counter supplies a one-cycle slot-boundary strobe together with the index of the slot that is starting.

At each boundary a small state machine reads the mask bit for the new slot and the blanking request. It then drives the transmitter output enable, a one-cycle transmit-empty request that asks the shifter for the next word, and an external line-buffer enable. The buffer enable is gated by three mode inputs. The machine has four states. ST_IDLE is held from reset until the first boundary. ST_SEND means the slot is enabled and driven. ST_MUTED means the mask bit is clear. ST_BLANKED means the slot is enabled but cancelled by a blanking write. The named transitions all happen on a boundary except the last. T_START_SEND enters ST_SEND when the mask bit is set and no blanking write arrives. T_START_MUTE enters ST_MUTED when the mask bit is clear. T_START_BLANK enters ST_BLANKED when the mask bit is set and a blanking write arrives in the same cycle. T_NULL_HIT moves ST_SEND to ST_BLANKED on a blanking write mid-slot. Every other cycle holds the state.

Top module: `tdm_slot_gate`

## Requirements
- R1: After reset every mask bit is set: address 0 and address 1 both read 0x00FFFF. All outputs stay low until the first slot boundary, and blanking writes before that boundary have no effect.
- R2: A write to address 0 stores wdata[15:0] as the enables for slots 0 to 15 (bit N is slot N). A write to address 1 stores the enables for slots 16 to 31 (bit N is slot N+16). Bits 23:16 always read zero, whatever was written to them.
- R3: From the cycle after a boundary until the next boundary, tx_oe is high if the mask bit for the starting slot is set, and low if it is clear.
- R4: tx_empty_req is high for exactly the one cycle after a boundary whose slot is enabled and not blanked at its start. It is low at all other times.
- R5: The mask is sampled only at boundaries. A mask write in the middle of a slot, or in the same cycle as a boundary, does not change the slot that is running or starting. It takes effect from the next boundary after it.
- R6: A write to address 2 in a cycle without a boundary blanks the running slot. From the next cycle, tx_oe and ext_buf_en are low until the following boundary. The slot after that is unaffected.
- R7: A write to address 2 in the same cycle as a boundary blanks the whole slot that is starting. tx_oe, ext_buf_en and tx_empty_req all stay low for that slot.
- R8: ext_buf_en equals tx_oe when mode_sync, mode_bufen and mode_fs_out are all high. Otherwise it is low.
- R9: Reads of address 2 (blanking register) and address 3 (unused) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 low mask half, 1 high mask half, 2 blanking |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for reg_addr (combinational) |
| slot_start | input | 1 | One-cycle slot-boundary strobe |
| slot_idx | input | 5 | Index of the slot starting with slot_start |
| mode_sync | input | 1 | Synchronous-mode enable for the buffer control |
| mode_bufen | input | 1 | Buffer-enable function selected |
| mode_fs_out | input | 1 | Frame-sync pin configured as output |
| tx_oe | output | 1 | Transmit data output enable for the current slot |
| tx_empty_req | output | 1 | One-cycle request for the next transmit word |
| ext_buf_en | output | 1 | External line-buffer enable |

## Verification
The hardest cases to reach are the ones where a register write lands in the same clock cycle as a slot boundary. The bench has to show that a mask write in that cycle does not affect the slot that is starting, and that a blanking write in that cycle cancels the new slot rather than the old one. The stimulus tasks raise slot_start and reg_we together at chosen slot indices. It also runs slots only one cycle long, so boundaries fall back to back and each new transmit-empty pulse follows directly on the last. A behavioural model tracks the mask and the slot status and is compared with all outputs on every cycle.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_MUTED,
        ST_BLANKED
    } gate_state_t;

endpackage

// File: rtl/tsg_mask_regs.sv
module tsg_mask_regs #(
    parameter int NUM_SLOTS = 32,
    parameter int HALF_W    = 16,
    parameter int WORD_W    = 24,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_SLOTS-1:0] mask_o,
    output logic                 null_hit_o
);
    localparam int NUM_HALVES = NUM_SLOTS / HALF_W;
    localparam logic [ADDR_W-1:0] NULL_ADDR = ADDR_W'(NUM_HALVES);

    // a write to the blanking address is a pulse, nothing is stored
    assign null_hit_o = reg_we && (reg_addr == NULL_ADDR);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic [HALF_W-1:0] half_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '1;
            end else if (reg_we && reg_addr == ADDR_W'(h)) begin
                half_q <= reg_wdata[HALF_W-1:0];
            end
        end

        assign mask_o[h*HALF_W +: HALF_W] = half_q;

        AST_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(h)) |=> (half_q == $past(reg_wdata[HALF_W-1:0]))); // R2
    end

    always_comb begin
        reg_rdata = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (reg_addr == ADDR_W'(h)) begin
                reg_rdata[HALF_W-1:0] = mask_o[h*HALF_W +: HALF_W];
            end
        end
    end

endmodule

// File: rtl/tsg_slot_pick.sv
module tsg_slot_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic [NUM_SLOTS-1:0] mask_i,
    input  logic [SLOT_W-1:0]    slot_idx_i,
    output logic                 enabled_o
);
    logic [NUM_SLOTS-1:0] hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g] = mask_i[g] && (slot_idx_i == SLOT_W'(g));
    end

    assign enabled_o = |hit;

endmodule

// File: rtl/tsg_gate_fsm.sv
module tsg_gate_fsm
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_start_i,
    input  logic slot_enabled_i,
    input  logic null_hit_i,
    output logic drive_o,
    output logic req_o
);
    gate_state_t state_q, state_d;
    logic        req_q;

    always_comb begin
        state_d = state_q;
        if (slot_start_i) begin
            if (!slot_enabled_i)  state_d = ST_MUTED;    // T_START_MUTE
            else if (null_hit_i)  state_d = ST_BLANKED;  // T_START_BLANK
            else                  state_d = ST_SEND;     // T_START_SEND
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SEND:    state_d = null_hit_i ? ST_BLANKED : ST_SEND; // T_NULL_HIT
                ST_MUTED:   state_d = ST_MUTED;
                ST_BLANKED: state_d = ST_BLANKED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= slot_start_i && slot_enabled_i && !null_hit_i;
        end
    end

    always_comb begin
        drive_o = 1'b0;
        unique case (state_q)
            ST_SEND:    drive_o = 1'b1;
            ST_IDLE,
            ST_MUTED,
            ST_BLANKED: drive_o = 1'b0;
            default:    drive_o = 1'b0;
        endcase
        req_o = req_q;
    end

    AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(slot_start_i)); // R4

    AST_MUTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && !slot_start_i) |=> (state_q == ST_MUTED)); // R5

    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANKED && !slot_start_i) |=> (state_q == ST_BLANKED)); // R6

endmodule

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
    parameter int NUM_SLOTS = 32,
    parameter int HALF_W    = 16,
    parameter int WORD_W    = 24,
    parameter int ADDR_W    = 2,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              mode_sync,
    input  logic              mode_bufen,
    input  logic              mode_fs_out,
    output logic              tx_oe,
    output logic              tx_empty_req,
    output logic              ext_buf_en
);
    logic [NUM_SLOTS-1:0] mask;
    logic                 null_hit;
    logic                 slot_enabled;
    logic                 buf_mode_on;

    tsg_mask_regs #(
        .NUM_SLOTS(NUM_SLOTS), .HALF_W(HALF_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mask_o     (mask),
        .null_hit_o (null_hit)
    );

    tsg_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .mask_i     (mask),
        .slot_idx_i (slot_idx),
        .enabled_o  (slot_enabled)
    );

    tsg_gate_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_start_i   (slot_start),
        .slot_enabled_i (slot_enabled),
        .null_hit_i     (null_hit),
        .drive_o        (tx_oe),
        .req_o          (tx_empty_req)
    );

    assign buf_mode_on = mode_sync && mode_bufen && mode_fs_out;
    assign ext_buf_en  = buf_mode_on && tx_oe;

    AST_NULL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (null_hit && !slot_start && tx_oe) |=> (!tx_oe && !ext_buf_en)); // R6

    AST_BLANK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && null_hit) |=> (!tx_oe && !tx_empty_req)); // R7

    AST_REQ_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_req |-> tx_oe); // R4

endmodule

// File: tb/tb_tdm_slot_gate.sv
module tb_tdm_slot_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        slot_start = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic        mode_sync = 1'b1, mode_bufen = 1'b1, mode_fs_out = 1'b1;
    logic        tx_oe, tx_empty_req, ext_buf_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model: 0 idle, 1 send, 2 muted, 3 blanked
    bit [31:0] m_mask = '1;
    int        m_stat = 0;
    bit        m_req  = 0;

    always #2 clk = ~clk;

    tdm_slot_gate dut (.*);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = '1; m_stat = 0; m_req = 0;
        end else begin
            bit hit_null;
            bit en;
            hit_null = reg_we && reg_addr == 2'd2;
            en = m_mask[slot_idx];
            m_req = slot_start && en && !hit_null;
            if (slot_start) m_stat = !en ? 2 : (hit_null ? 3 : 1);
            else if (m_stat == 1 && hit_null) m_stat = 3;
            if (reg_we && reg_addr == 2'd0) m_mask[15:0]  = reg_wdata[15:0];
            if (reg_we && reg_addr == 2'd1) m_mask[31:16] = reg_wdata[15:0];
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit oe_e;
            bit [23:0] rd_e;
            oe_e = (m_stat == 1);
            rd_e = reg_addr == 2'd0 ? {8'h0, m_mask[15:0]} :
                   reg_addr == 2'd1 ? {8'h0, m_mask[31:16]} : 24'h0;
            cmp("tx_oe", int'(tx_oe), int'(oe_e));
            cmp("tx_empty_req", int'(tx_empty_req), int'(m_req));
            cmp("ext_buf_en", int'(ext_buf_en), int'(oe_e && mode_sync && mode_bufen && mode_fs_out));
            cmp("reg_rdata", int'(reg_rdata), int'(rd_e));
        end
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // one clock: drive inputs just after the rising edge
    task automatic cyc(input bit ss, input int idx, input bit we, input int addr, input int data);
        @(posedge clk); #1;
        slot_start = ss; slot_idx = 5'(idx);
        reg_we = we; reg_addr = 2'(addr); reg_wdata = 24'(data);
    endtask

    task automatic slot(input int idx, input int len);
        cyc(1, idx, 0, 0, 0);
        for (int i = 1; i < len; i++) cyc(0, idx, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: idle after reset, blanking ignored, mask reads all ones
        tag = "R1";
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 2, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        // R3/R4: enabled slots
        tag = "R3";
        for (int s = 0; s < 4; s++) slot(s, 3);
        // R2: halves, reserved bits read zero
        tag = "R2";
        cyc(0, 3, 1, 0, 24'hFFA5A5);
        cyc(0, 3, 1, 1, 24'h120F0F);
        cyc(0, 3, 0, 0, 0);
        cyc(0, 3, 0, 1, 0);
        tag = "R3";
        for (int s = 0; s < 32; s++) slot(s, 2);
        // R4: back-to-back one-cycle slots
        tag = "R4";
        for (int s = 0; s < 32; s++) slot(s, 1);
        slot(0, 2);
        // R5: mid-slot and coincident mask writes
        tag = "R5";
        cyc(1, 5, 0, 0, 0);            // slot 5 enabled (A5A5 bit5=1)
        cyc(0, 5, 1, 0, 24'h0000);     // disable all low slots mid-slot
        cyc(0, 5, 0, 0, 0);
        cyc(1, 5, 1, 0, 24'hFFFF);     // coincident write: slot 5 still muted
        cyc(0, 5, 0, 0, 0);
        slot(5, 3);                    // now enabled
        cyc(1, 20, 1, 1, 24'h0000);    // slot 20 uses old high half (0F0F: bit4=0)
        cyc(0, 20, 0, 1, 0);
        slot(16, 2);                   // muted now
        cyc(0, 16, 1, 1, 24'hFFFF);
        // R6: mid-slot blanking
        tag = "R6";
        cyc(1, 7, 0, 0, 0);
        cyc(0, 7, 0, 0, 0);
        cyc(0, 7, 1, 2, 24'h123456);
        cyc(0, 7, 0, 2, 0);
        cyc(0, 7, 0, 0, 0);
        slot(8, 3);
        // R7: blanking coincident with boundary
        tag = "R7";
        cyc(1, 9, 1, 2, 0);
        cyc(0, 9, 0, 0, 0);
        cyc(0, 9, 0, 0, 0);
        slot(10, 2);
        // R8: buffer-enable mode combinations
        tag = "R8";
        for (int m = 0; m < 8; m++) begin
            cyc(1, m, 0, 0, 0);
            mode_sync = m[0]; mode_bufen = m[1]; mode_fs_out = m[2];
            cyc(0, m, 0, 0, 0);
            cyc(0, m, 0, 0, 0);
        end
        // R9: blanking and unused addresses read zero
        tag = "R9";
        cyc(0, 0, 0, 2, 0);
        cyc(0, 0, 0, 3, 0);
        cyc(0, 0, 0, 3, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule